// File: doc/BRIEF.md
# Windowed Bidirectional Bit-Shift Register

The block keeps a 128-bit status array and treats a programmable slice of it as a shift register. The slice starts at a head index and covers a given number of consecutive positions. Each time the pulse input goes from low to high, the slice moves one place. A forward move pushes the bits toward higher indices. A reverse move pushes them toward lower indices. The data input fills the position that the move leaves empty. A clear input zeroes the slice. Positions outside the slice are never written.

The pulse, data, direction and configuration pins are plain control inputs sampled on the clock. The strobe that causes a move is the pulse's rising edge, so no valid/ready handshake applies. There is no back-pressure: an edge that arrives while a move is blocked (clear active or configuration invalid) is consumed and lost. The full array is visible at all times, so surrounding logic can read any bit directly.

Top module: `seg_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 128 array bits and the stored pulse history become 0.
- R2: A move happens only in a cycle where `pulse` is 1 and was 0 at the previous clock edge. A pulse held high produces exactly one move. The array changes at the first clock edge that samples the high pulse.
- R3: Forward move (`dir_rev`=0): each slice bit at index i, for i > head, takes the old value at i-1, and the bit at head takes `din`.
- R4: Reverse move (`dir_rev`=1): each slice bit at index i, for i < head+len-1, takes the old value at i+1, and the last bit (head+len-1) takes `din`.
- R5: With `clr`=1 at a clock edge, every slice bit becomes 0. `clr` takes priority over a coincident pulse edge.
- R6: Bits outside [head, head+len-1] keep their value across moves and clears.
- R7: `cfg_err` is 1 combinationally whenever `len`=0 or head+len > 128. While it is 1, the array does not change.
- R8: The pulse history is updated in every cycle, including cycles with `clr` or `cfg_err`. An edge absorbed there does not cause a move after they drop while the pulse stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear the slice |
| pulse | input | 1 | Move strobe, acts on its rising edge |
| din | input | 1 | Bit loaded into the vacated slice position |
| dir_rev | input | 1 | 0 = toward higher indices, 1 = toward lower |
| head | input | 7 | Lowest index of the slice |
| len | input | 8 | Number of slice bits, 1 to 128 |
| bits | output | 128 | Whole status array |
| cfg_err | output | 1 | Slice does not fit in the array |

## Verification
The bench uses a one-bit slice, which a design could corrupt by treating head and tail as distinct positions. It uses a full 128-bit slice and a slice ending at bit 127, where an off-by-one in the neighbour selection would read past the array or write outside the slice. A pulse held high for many cycles catches a design that moves on level instead of on edge. A clear asserted together with the rising edge catches a design that lets the edge slip through afterwards. Random slices with alternating directions and out-of-range configurations compare every bit, so a leak into neighbouring positions or a move during an error shows up as a mismatch.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_ARRAY_N = 128;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } seg_dir_e;
endpackage

// File: rtl/seg_edge.sv
module seg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic fire
);
  logic pulse_q;

  // history is refreshed every cycle, regardless of clear or error (R8)
  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse;
  end

  assign fire = pulse & ~pulse_q;

  // R2: two consecutive strobes are impossible
  p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/seg_window.sv
module seg_window #(
  parameter int N  = 128,
  parameter int IW = $clog2(N),
  parameter int LW = $clog2(N + 1)
) (
  input  logic [IW-1:0] head,
  input  logic [LW-1:0] len,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  head_hot,
  output logic [N-1:0]  tail_hot,
  output logic          err
);
  localparam int EW = LW + 1;

  logic [EW-1:0] stop_ix;
  logic [EW-1:0] last_ix;
  logic [EW-1:0] head_x;

  assign head_x  = EW'(head);
  assign stop_ix = head_x + EW'(len);
  assign last_ix = stop_ix - EW'(1);
  assign err     = (len == '0) || (stop_ix > EW'(N));

  for (genvar i = 0; i < N; i++) begin : g_pos
    localparam logic [EW-1:0] POS = EW'(i);
    assign mask[i]     = (POS >= head_x) && (POS < stop_ix);
    assign head_hot[i] = (POS == head_x);
    assign tail_hot[i] = (POS == last_ix);
  end

  // R7: a valid slice has exactly one head and one tail inside it
  always_comb begin
    if (!err) begin
      a_one_head_r7: assert ($countones(head_hot & mask) == 1);
      a_one_tail_r7: assert ($countones(tail_hot & mask) == 1);
    end
  end
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter
  import seg_pkg::*;
#(
  parameter int N  = SEG_ARRAY_N,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pulse,
  input  logic          din,
  input  logic          dir_rev,
  input  logic [IW-1:0] head,
  input  logic [LW-1:0] len,
  output logic [N-1:0]  bits,
  output logic          cfg_err
);
  logic          fire;
  logic [N-1:0]  mask, head_hot, tail_hot;
  logic [N-1:0]  bits_q, bits_d;
  seg_dir_e      dir;

  assign dir = seg_dir_e'(dir_rev);

  seg_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (pulse),
    .fire  (fire)
  );

  seg_window #(.N(N), .IW(IW), .LW(LW)) u_win (
    .head     (head),
    .len      (len),
    .mask     (mask),
    .head_hot (head_hot),
    .tail_hot (tail_hot),
    .err      (cfg_err)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lo_nb, hi_nb, moved;
    if (i == 0) begin : g_lo0
      assign lo_nb = 1'b0;
    end else begin : g_lo
      assign lo_nb = bits_q[i-1];
    end
    if (i == N - 1) begin : g_hiN
      assign hi_nb = 1'b0;
    end else begin : g_hi
      assign hi_nb = bits_q[i+1];
    end
    assign moved = (dir == DIR_FWD) ? (head_hot[i] ? din : lo_nb)
                                    : (tail_hot[i] ? din : hi_nb);
    assign bits_d[i] = (cfg_err || !mask[i]) ? bits_q[i] :
                       clr                   ? 1'b0      :
                       fire                  ? moved     : bits_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits = bits_q;

  // R6: positions outside the slice never change
  p_outside_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((bits ^ $past(bits)) & ~$past(mask)) == '0));
  // R7: invalid configuration freezes the array
  p_err_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (bits == $past(bits)));
  // R5: clear empties the slice
  p_clear_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cfg_err) |=> ((bits & $past(mask)) == '0));
  // R2: no move without a new edge
  p_no_level_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(bits));
endmodule

// File: tb/tb_seg_shifter.sv
module tb_seg_shifter;
  localparam int N = 128;

  logic          clk = 1'b0;
  logic          rst_n, clr, pulse, din, dir_rev;
  logic [6:0]    head;
  logic [7:0]    len;
  logic [N-1:0]  bits;
  logic          cfg_err;

  int            n_checks = 0;
  int            n_errs   = 0;
  logic [N-1:0]  ref_bits;
  logic          ref_prev;

  always #2 clk = ~clk;

  seg_shifter dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pulse(pulse), .din(din),
    .dir_rev(dir_rev), .head(head), .len(len), .bits(bits), .cfg_err(cfg_err)
  );

  function automatic logic bad_cfg(input int h, input int l);
    return (l == 0) || (h + l > N);
  endfunction

  function automatic logic [N-1:0] model_next(
    input logic [N-1:0] cur, input logic c, input logic e,
    input logic d, input logic rv, input int h, input int l);
    logic [N-1:0] r;
    r = cur;
    if (bad_cfg(h, l)) return r;
    if (c) begin
      for (int i = h; i < h + l; i++) r[i] = 1'b0;
    end else if (e) begin
      if (!rv) begin
        for (int i = h + l - 1; i > h; i--) r[i] = cur[i-1];
        r[h] = d;
      end else begin
        for (int i = h; i < h + l - 1; i++) r[i] = cur[i+1];
        r[h+l-1] = d;
      end
    end
    return r;
  endfunction

  task automatic check_bits(input string tag);
    n_checks++;
    if (bits !== ref_bits) begin
      n_errs++;
      $display("FAIL %s: bits actual=%h expected=%h", tag, bits, ref_bits);
    end
  endtask

  task automatic check_err(input string tag, input logic exp);
    n_checks++;
    if (cfg_err !== exp) begin
      n_errs++;
      $display("FAIL %s: cfg_err actual=%b expected=%b", tag, cfg_err, exp);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic p,
                      input logic d, input logic rv, input int h, input int l);
    logic e;
    @(negedge clk);
    clr = c; pulse = p; din = d; dir_rev = rv;
    head = 7'(h); len = 8'(l);
    #1;
    check_err({tag, "/R7"}, bad_cfg(h, l));
    e = p && !ref_prev;
    ref_bits = model_next(ref_bits, c, e, d, rv, h, l);
    ref_prev = p;
    @(posedge clk); #1;
    check_bits(tag);
  endtask

  // one full move: pulse low then high
  task automatic move(input string tag, input logic d, input logic rv,
                      input int h, input int l);
    step(tag, 1'b0, 1'b0, d, rv, h, l);
    step(tag, 1'b0, 1'b1, d, rv, h, l);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0107));
    rst_n = 1'b0; clr = 1'b0; pulse = 1'b0; din = 1'b0; dir_rev = 1'b0;
    head = '0; len = 8'd4;
    ref_bits = '0; ref_prev = 1'b0;
    repeat (3) @(posedge clk);
    #1; check_bits("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    // fill a full 128-bit slice forward with a pattern
    for (int k = 0; k < 130; k++) move("R3 full fwd", 1'(k % 3 == 0), 1'b0, 0, 128);
    // full slice reverse
    for (int k = 0; k < 20; k++) move("R4 full rev", 1'(k & 1), 1'b1, 0, 128);

    // length 1 at several places, both directions
    move("R3 len1 fwd", 1'b0, 1'b0, 0, 1);
    move("R4 len1 rev", 1'b1, 1'b1, 127, 1);
    move("R3 len1 mid", 1'b1, 1'b0, 64, 1);
    move("R4 len1 mid", 1'b0, 1'b1, 65, 1);

    // slice ending at bit 127, alternating directions (R6 neighbours checked)
    for (int k = 0; k < 16; k++) move("R6 tail127 alt", 1'(k % 5 == 1), 1'(k & 1), 120, 8);

    // pulse held high: only one move (R2)
    step("R2 held low", 1'b0, 1'b0, 1'b1, 1'b0, 10, 12);
    for (int k = 0; k < 40; k++) step("R2 held high", 1'b0, 1'b1, 1'(k & 1), 1'(k & 1), 10, 12);

    // clear with coincident edge; edge absorbed (R5, R8)
    step("R5 pre", 1'b0, 1'b0, 1'b1, 1'b0, 3, 30);
    step("R5 clr+edge", 1'b1, 1'b1, 1'b1, 1'b0, 3, 30);
    step("R8 after clr held", 1'b0, 1'b1, 1'b1, 1'b0, 3, 30);
    step("R8 after clr held2", 1'b0, 1'b1, 1'b1, 1'b0, 3, 30);

    // invalid configs: edge absorbed, then no move (R7, R8)
    step("R7 pre", 1'b0, 1'b0, 1'b1, 1'b0, 100, 29);
    step("R7 overrun", 1'b0, 1'b1, 1'b1, 1'b0, 100, 29);
    step("R8 after err", 1'b0, 1'b1, 1'b1, 1'b0, 100, 28);
    step("R7 len0", 1'b1, 1'b0, 1'b1, 1'b0, 5, 0);
    step("R7 len255", 1'b1, 1'b1, 1'b1, 1'b0, 0, 255);
    step("R7 edge fit", 1'b0, 1'b0, 1'b0, 1'b0, 1, 128);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      int h, l, sel;
      sel = int'($urandom_range(0, 9));
      h = int'($urandom_range(0, 127));
      if (sel == 0)      l = 1;
      else if (sel == 1) begin h = 0; l = 128; end
      else if (sel == 2) l = 128 - h;
      else if (sel == 3) l = int'($urandom_range(0, 255));
      else               l = int'($urandom_range(1, 128 - h));
      step("R3/R4/R6 random", 1'($urandom_range(0, 19) == 0),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), h, l);
    end

    // reset clears everything again
    @(negedge clk); rst_n = 1'b0; ref_bits = '0; ref_prev = 1'b0; pulse = 1'b0;
    @(posedge clk); #1; check_bits("R1 re-reset");
    finish_run();
  end
endmodule